// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits on a memory-mapped write port in front of a command processor. Software registers command queues through a side-band command port. After that, it rings a queue by writing that queue's new write index into the queue's doorbell slot. The block keeps one valid bit per queue ID. It maps every incoming doorbell write back to a queue ID. For each accepted write it issues a single-cycle pulse that carries the queue ID and the decoded 64-bit write index.

A mode input selects the doorbell format:

- **4-byte format.** Slots are spaced 4 bytes apart. The low 32 bits of the written value are the write index.
- **8-byte format.** Slots are spaced 8 bytes apart. The written 64-bit value is one below the write index, so the block adds one to it.

The block raises a one-cycle error flag, at the same cycle position as the index pulse, for each of these cases:

- a write whose byte size does not match the format;
- a write that lands on no registered slot;
- a duplicate registration;
- removal of a queue that is not registered;
- registration of a queue that is outside the table or outside the doorbell window.

Top module: `doorbell_decoder`

## Requirements
- R1: With `wide_mode` = 0 each queue slot is 4 bytes and with `wide_mode` = 1 it is 8 bytes. Queue q owns byte offset q × slot size. An accepted write to that offset reports `idx_qid` = q.
- R2: A doorbell write whose `wr_size` (in bytes) differs from the current slot size pulses `err_size` and produces no `idx_valid`.
- R3: In 8-byte mode an accepted write reports `idx_value` = `wr_data` + 1, modulo 2^64. All-ones data therefore reports zero.
- R4: In 4-byte mode an accepted write reports `wr_data[31:0]` zero-extended to 64 bits. Bits 63:32 of `wr_data` are ignored.
- R5: A register command (`cmd_valid` = 1, `cmd_remove` = 0) marks the queue as registered. It is refused with an `err_range` pulse, and the table is left unchanged, in either of two cases:
  - `cmd_qid` is not below MAX_Q;
  - `cmd_qid` × slot size is greater than DB_WINDOW bytes.
- R6: Registering a queue that is already registered pulses `err_dup` and leaves the table unchanged.
- R7: A remove command (`cmd_valid` = 1, `cmd_remove` = 1) for a registered queue frees that queue. A remove for a queue that is not registered or is outside the table pulses `err_stale`.
- R8: A correctly sized doorbell write is dropped with an `err_unmapped` pulse, and no `idx_valid`, in any of these cases:
  - its offset is not a multiple of the slot size;
  - it maps to a queue ID not below MAX_Q;
  - it maps to a queue that is not registered.
- R9: All outputs are registered. Each result appears in the cycle after the clock edge that samples the write or command, and lasts exactly one cycle unless a new input repeats it. At most one of `idx_valid`, `err_size` and `err_unmapped` is high in any cycle.
- R10: A doorbell write and a command in the same cycle are handled as follows. The write is judged against the table as it stood before that command.
- R11: While `rst_n` is low, and right after reset, every output is low and no queue is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 0 selects 4-byte doorbells, 1 selects 8-byte doorbells |
| wr_en | input | 1 | Doorbell write strobe |
| wr_off | input | ADDR_W | Byte offset of the write inside the doorbell window |
| wr_size | input | 4 | Byte size of the write |
| wr_data | input | DATA_W | Write data |
| cmd_valid | input | 1 | Queue command strobe |
| cmd_remove | input | 1 | 0 registers the queue, 1 removes it |
| cmd_qid | input | QID_W | Queue ID of the command |
| idx_valid | output | 1 | One-cycle pulse for an accepted doorbell |
| idx_qid | output | QID_W | Queue ID of the accepted doorbell |
| idx_value | output | DATA_W | Decoded write index |
| err_size | output | 1 | Write size did not match the slot size |
| err_unmapped | output | 1 | Write hit no registered slot |
| err_dup | output | 1 | Register command for an already registered queue |
| err_stale | output | 1 | Remove command for a queue that is not registered |
| err_range | output | 1 | Register command outside the table or the window |

## Verification
The bench targets the points where the two formats disagree, each of which exposes a specific kind of fault:

- **Slot stride.** The same offset is written in both modes. A decoder with a fixed stride reports the wrong queue or misses the misaligned case.
- **Plus-one rule.** All-ones data is used in 8-byte mode. A design that forgets the increment is off by one, and one that saturates does not report zero.
- **Zero extension.** In 4-byte mode the upper data half carries a pattern. A design that skips zero extension leaks that pattern into the index.
- **Window edge.** The bench runs with a small window so that a queue exactly at the window edge is accepted while the next one is refused only in 8-byte mode. A wrong comparison direction refuses the edge queue.
- **Same-cycle command and write.** Commands that coincide with writes to the same queue show whether the table is read before or after the update. A bypassed table accepts a write to a queue registered only in that cycle.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

   typedef enum logic {
      DB_NARROW = 1'b0,
      DB_WIDE   = 1'b1
   } db_mode_e;

   localparam int unsigned NARROW_BYTES = 4;
   localparam int unsigned WIDE_BYTES   = 8;
   localparam int unsigned NARROW_DW    = 32;

   function automatic logic [3:0] slot_bytes(input db_mode_e m);
      return (m == DB_WIDE) ? 4'(WIDE_BYTES) : 4'(NARROW_BYTES);
   endfunction

   function automatic int unsigned slot_shift(input db_mode_e m);
      return (m == DB_WIDE) ? 3 : 2;
   endfunction

endpackage

// File: rtl/doorbell_addr_dec.sv
module doorbell_addr_dec
   import doorbell_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned QID_W  = 8,
   parameter int unsigned MAX_Q  = 16
) (
   input  db_mode_e            mode,
   input  logic [ADDR_W-1:0]   off,
   output logic [QID_W-1:0]    qid,
   output logic                aligned,
   output logic                in_table
);

   logic [ADDR_W-1:0] slot;

   always_comb begin
      slot     = off >> slot_shift(mode);
      aligned  = (mode == DB_WIDE) ? (off[2:0] == 3'b000) : (off[1:0] == 2'b00);
      in_table = (32'(slot) < MAX_Q);
      qid      = QID_W'(slot);
   end

endmodule

// File: rtl/doorbell_table.sv
module doorbell_table
   import doorbell_pkg::*;
#(
   parameter int unsigned MAX_Q     = 16,
   parameter int unsigned QID_W     = 8,
   parameter int unsigned DB_WINDOW = 4096,
   localparam int unsigned QI       = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
   localparam int unsigned TAB_N    = 1 << QI
) (
   input  logic              clk,
   input  logic              rst_n,
   input  db_mode_e          mode,
   input  logic              cmd_valid,
   input  logic              cmd_remove,
   input  logic [QID_W-1:0]  cmd_qid,
   output logic [TAB_N-1:0]  valid_o,
   output logic              err_dup_o,
   output logic              err_stale_o,
   output logic              err_range_o
);

   logic [TAB_N-1:0] valid_q;
   logic [QI-1:0]    sel;
   logic [31:0]      off32;
   logic             in_tab, too_far, hit;
   logic             do_set, do_clr;

   always_comb begin
      sel     = QI'(cmd_qid);
      in_tab  = (32'(cmd_qid) < MAX_Q);
      off32   = 32'(cmd_qid) << slot_shift(mode);
      too_far = (off32 > 32'(DB_WINDOW));
      hit     = in_tab && valid_q[sel];
      do_set  = cmd_valid && !cmd_remove && in_tab && !too_far && !hit;
      do_clr  = cmd_valid && cmd_remove && hit;
   end

   for (genvar i = 0; i < TAB_N; i++) begin : g_entry
      if (i < MAX_Q) begin : g_live
         logic v_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               v_q <= 1'b0;
            else if (do_set && (sel == QI'(i)))
               v_q <= 1'b1;
            else if (do_clr && (sel == QI'(i)))
               v_q <= 1'b0;
         end
         assign valid_q[i] = v_q;
      end else begin : g_pad
         assign valid_q[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_dup_o   <= 1'b0;
         err_stale_o <= 1'b0;
         err_range_o <= 1'b0;
      end else begin
         err_range_o <= cmd_valid && !cmd_remove && (!in_tab || too_far);
         err_dup_o   <= cmd_valid && !cmd_remove && in_tab && !too_far && hit;
         err_stale_o <= cmd_valid && cmd_remove && !hit;
      end
   end

   assign valid_o = valid_q;

   assert_dup_keeps_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_dup_o |-> $stable(valid_q));

   assert_stale_keeps_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_stale_o |-> $stable(valid_q));

   assert_range_keeps_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_range_o |-> $stable(valid_q));

   assert_one_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(valid_q ^ $past(valid_q)) <= 1);

endmodule

// File: rtl/doorbell_decoder.sv
module doorbell_decoder
   import doorbell_pkg::*;
#(
   parameter int unsigned MAX_Q     = 16,
   parameter int unsigned QID_W     = 8,
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned DB_WINDOW = 4096
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wide_mode,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_off,
   input  logic [3:0]         wr_size,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               cmd_valid,
   input  logic               cmd_remove,
   input  logic [QID_W-1:0]   cmd_qid,
   output logic               idx_valid,
   output logic [QID_W-1:0]   idx_qid,
   output logic [DATA_W-1:0]  idx_value,
   output logic               err_size,
   output logic               err_unmapped,
   output logic               err_dup,
   output logic               err_stale,
   output logic               err_range
);

   localparam int unsigned QI    = (MAX_Q > 1) ? $clog2(MAX_Q) : 1;
   localparam int unsigned TAB_N = 1 << QI;
   localparam int unsigned NW    = NARROW_DW;

   if (MAX_Q < 1) begin : g_chk_maxq
      $error("MAX_Q must be at least one");
   end
   if ((1 << QID_W) < MAX_Q) begin : g_chk_qid
      $error("QID_W too narrow for MAX_Q");
   end
   if (DATA_W <= NW) begin : g_chk_data
      $error("DATA_W must exceed the narrow doorbell width");
   end
   if (ADDR_W < 4) begin : g_chk_addr
      $error("ADDR_W too narrow");
   end

   db_mode_e          mode;
   logic [TAB_N-1:0]  valid_vec;
   logic [QID_W-1:0]  dec_qid;
   logic              dec_aligned, dec_in_tab;
   logic              size_ok, slot_hit, accept;
   logic [DATA_W-1:0] next_idx;

   assign mode = db_mode_e'(wide_mode);

   doorbell_addr_dec #(
      .ADDR_W (ADDR_W),
      .QID_W  (QID_W),
      .MAX_Q  (MAX_Q)
   ) u_dec (
      .mode     (mode),
      .off      (wr_off),
      .qid      (dec_qid),
      .aligned  (dec_aligned),
      .in_table (dec_in_tab)
   );

   doorbell_table #(
      .MAX_Q     (MAX_Q),
      .QID_W     (QID_W),
      .DB_WINDOW (DB_WINDOW)
   ) u_tab (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .cmd_valid   (cmd_valid),
      .cmd_remove  (cmd_remove),
      .cmd_qid     (cmd_qid),
      .valid_o     (valid_vec),
      .err_dup_o   (err_dup),
      .err_stale_o (err_stale),
      .err_range_o (err_range)
   );

   always_comb begin
      size_ok  = (wr_size == slot_bytes(mode));
      slot_hit = dec_aligned && dec_in_tab && valid_vec[QI'(dec_qid)];
      accept   = wr_en && size_ok && slot_hit;
      if (mode == DB_WIDE)
         next_idx = wr_data + DATA_W'(1);
      else
         next_idx = {{(DATA_W-NW){1'b0}}, wr_data[NW-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_valid    <= 1'b0;
         idx_qid      <= '0;
         idx_value    <= '0;
         err_size     <= 1'b0;
         err_unmapped <= 1'b0;
      end else begin
         idx_valid    <= accept;
         err_size     <= wr_en && !size_ok;
         err_unmapped <= wr_en && size_ok && !slot_hit;
         if (accept) begin
            idx_qid   <= dec_qid;
            idx_value <= next_idx;
         end
      end
   end

   assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({idx_valid, err_size, err_unmapped}));

   assert_index_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> $past(wr_en));

   assert_size_err_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_size |-> $past(wr_en));

   assert_slot_size_matched_R1: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> ($past(wr_size) == ($past(wide_mode) ? 4'd8 : 4'd4)));

   assert_narrow_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_valid && !$past(wide_mode)) |-> (idx_value[DATA_W-1:NW] == '0));

endmodule

// File: tb/doorbell_decoder_tb.sv
module doorbell_decoder_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MAXQ   = 16;
   localparam int WINDOW = 64;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wide_mode;
   logic        wr_en;
   logic [12:0] wr_off;
   logic [3:0]  wr_size;
   logic [63:0] wr_data;
   logic        cmd_valid, cmd_remove;
   logic [7:0]  cmd_qid;
   logic        idx_valid;
   logic [7:0]  idx_qid;
   logic [63:0] idx_value;
   logic        err_size, err_unmapped, err_dup, err_stale, err_range;

   int checks = 0;
   int errors = 0;

   logic [MAXQ-1:0] mtab;
   logic        e_iv, e_es, e_eu, e_ed, e_est, e_er;
   int          e_qid;
   logic [63:0] e_val;

   always #(CLK_PERIOD/2) clk = ~clk;

   doorbell_decoder #(
      .MAX_Q     (MAXQ),
      .QID_W     (8),
      .ADDR_W    (13),
      .DATA_W    (64),
      .DB_WINDOW (WINDOW)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wide_mode    (wide_mode),
      .wr_en        (wr_en),
      .wr_off       (wr_off),
      .wr_size      (wr_size),
      .wr_data      (wr_data),
      .cmd_valid    (cmd_valid),
      .cmd_remove   (cmd_remove),
      .cmd_qid      (cmd_qid),
      .idx_valid    (idx_valid),
      .idx_qid      (idx_qid),
      .idx_value    (idx_value),
      .err_size     (err_size),
      .err_unmapped (err_unmapped),
      .err_dup      (err_dup),
      .err_stale    (err_stale),
      .err_range    (err_range)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic compare(input string req);
      chk(req, "idx_valid", 64'(idx_valid), 64'(e_iv));
      chk(req, "err_size", 64'(err_size), 64'(e_es));
      chk(req, "err_unmapped", 64'(err_unmapped), 64'(e_eu));
      chk(req, "err_dup", 64'(err_dup), 64'(e_ed));
      chk(req, "err_stale", 64'(err_stale), 64'(e_est));
      chk(req, "err_range", 64'(err_range), 64'(e_er));
      if (e_iv) begin
         chk(req, "idx_qid", 64'(idx_qid), 64'(e_qid));
         chk(req, "idx_value", idx_value, e_val);
      end
   endtask

   // One clock: drive inputs, predict from the model, compare after the edge.
   task automatic apply(input bit we, input int off, input int sz, input logic [63:0] d,
                        input bit cv, input bit crm, input int cq, input string req);
      int dsz;
      int slot;
      wr_en = we; wr_off = 13'(off); wr_size = 4'(sz); wr_data = d;
      cmd_valid = cv; cmd_remove = crm; cmd_qid = 8'(cq);
      dsz = wide_mode ? 8 : 4;
      e_iv = 0; e_es = 0; e_eu = 0; e_ed = 0; e_est = 0; e_er = 0;
      if (we) begin
         slot = off / dsz;
         if (sz != dsz) e_es = 1;
         else if ((off % dsz) != 0 || slot >= MAXQ || !mtab[slot]) e_eu = 1;
         else begin
            e_iv  = 1;
            e_qid = slot;
            e_val = wide_mode ? d + 64'd1 : {32'h0, d[31:0]};
         end
      end
      if (cv) begin
         if (!crm) begin
            if (cq >= MAXQ || cq * dsz > WINDOW) e_er = 1;
            else if (mtab[cq]) e_ed = 1;
            else mtab[cq] = 1'b1;
         end else begin
            if (cq >= MAXQ || !mtab[cq]) e_est = 1;
            else mtab[cq] = 1'b0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   task automatic idle(input string req);
      apply(0, 0, 0, 64'h0, 0, 0, 0, req);
   endtask

   task automatic ring(input int off, input int sz, input logic [63:0] d, input string req);
      apply(1, off, sz, d, 0, 0, 0, req);
   endtask

   task automatic qreg(input int q, input string req);
      apply(0, 0, 0, 64'h0, 1, 0, q, req);
   endtask

   task automatic qdel(input int q, input string req);
      apply(0, 0, 0, 64'h0, 1, 1, q, req);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      mtab = '0;
      rst_n = 1'b0; wide_mode = 1'b0;
      wr_en = 0; wr_off = '0; wr_size = '0; wr_data = '0;
      cmd_valid = 0; cmd_remove = 0; cmd_qid = '0;
      e_iv = 0; e_es = 0; e_eu = 0; e_ed = 0; e_est = 0; e_er = 0; e_qid = 0; e_val = '0;
      // R11: outputs low while reset is held, even with stimulus present
      wr_en = 1; wr_size = 4'd8; cmd_valid = 1;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); @(negedge clk);
         compare("R11");
      end
      wr_en = 0; cmd_valid = 0;
      rst_n = 1'b1;
      idle("R11");
      // R11: table starts empty
      ring(0, 4, 64'h5, "R11");

      // Narrow mode registrations
      qreg(0, "R5");
      qreg(3, "R5");
      qreg(15, "R5");
      qreg(16, "R5");                  // outside the table
      qreg(200, "R5");
      qreg(3, "R6");                   // duplicate
      ring(12, 4, 64'hDEAD_BEEF_1234_5678, "R4");   // queue 3, upper half ignored
      ring(12, 4, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
      ring(13, 4, 64'h1, "R8");        // misaligned
      ring(64, 4, 64'h1, "R8");        // queue 16, outside table
      ring(8, 4, 64'h1, "R8");         // queue 2 not registered
      ring(12, 8, 64'h1, "R2");        // wrong size for narrow
      ring(12, 2, 64'h1, "R2");
      ring(0, 4, 64'h11, "R9");        // back-to-back writes
      ring(60, 4, 64'h22, "R9");
      idle("R9");
      qreg(9, "R5");                   // 36 <= window in narrow mode

      // Wide mode
      wide_mode = 1'b1;
      ring(24, 8, 64'h5, "R3");        // queue 3
      ring(24, 8, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
      ring(120, 8, 64'h1234_0000_0000_0000, "R1");  // queue 15
      ring(72, 8, 64'h7, "R1");        // queue 9 still registered
      ring(12, 8, 64'h1, "R8");        // misaligned for wide
      ring(24, 4, 64'h1, "R2");        // narrow size in wide mode
      qreg(8, "R5");                   // 64 bytes, exactly at window
      qreg(10, "R5");                  // 80 bytes, beyond window
      ring(80, 8, 64'h3, "R5");        // queue 10 not registered
      ring(64, 8, 64'h3, "R5");        // queue 8 registered

      // Removal
      qdel(5, "R7");
      qdel(20, "R7");
      qdel(3, "R7");
      ring(24, 8, 64'h1, "R7");
      qdel(3, "R7");

      // Same-cycle command and write
      apply(1, 40, 8, 64'h9, 1, 0, 5, "R10");   // register 5 with write to 5
      ring(40, 8, 64'h9, "R10");
      apply(1, 0, 8, 64'h4, 1, 1, 0, "R10");    // remove 0 with write to 0
      ring(0, 8, 64'h4, "R10");

      // Mode flip reinterprets offsets
      wide_mode = 1'b0;
      ring(20, 4, 64'hAAAA_5555, "R1");         // queue 5 in narrow mode
      ring(40, 4, 64'h1, "R1");                 // queue 10 not registered
      idle("R9");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule